// File: doc/BRIEF.md
# Block-transfer micro-op sequencer

This block turns one load-multiple or store-multiple request into an ordered stream of simple micro-operations for an execution pipeline. A request holds a register mask, a base register number and four mode bits: load or store, ascending or descending addresses, base update after the transfer, and the user-bank form. The sequencer accepts a request only when it is idle. It then presents one micro-op at a time on a valid/ready handshake and reports the total number of micro-ops in the sequence.

The first micro-op copies the base into scratch register 0, and every access is addressed from that copy. When a load also updates its base, the highest listed register is loaded into scratch register 1. The base adjustment and the move from scratch register 1 into its real destination come only after every memory access. A fault during any access therefore leaves both the base and the final register unmodified.

Register numbers on the micro-op fields are 5 bits wide. Values 0 to 15 are architectural registers, with 13 as the stack pointer and 15 as the program counter. Value 16 is scratch register 0 and value 17 is scratch register 1.

Top module: `lsm_uop_seq`

## Requirements
- R1: While a sequence is presented, `uop_count` equals the number of micro-ops it contains. For a mask with n set bits and n > 0, that count is n + 1, plus 2 for a load with base update or plus 1 for a store with base update. For an empty mask it is 1.
- R2: An empty mask yields exactly one micro-op. It is the base copy (opcode 0), and its last flag is set.
- R3: The first micro-op of every sequence has opcode 0 (add immediate), destination 16, source equal to the base register and immediate 0.
- R4: Memory micro-ops follow in order of rising register number, one per set bit, each with source 16. Opcodes are 2 (load), 3 (return load) and 4 (store). For the k-th access (k counted from 0), the immediate is 4k when ascending and 4(n-k) when descending. `uop_up` carries the direction bit.
- R5: In a load with base update, the access for the highest listed register writes destination 17.
- R6: With base update, one micro-op follows the accesses. Its destination and source are both the base register and its immediate is 4n. Its opcode is 0 (add) when ascending and 1 (subtract) when descending.
- R7: In a load with base update, a last micro-op with source 17 moves the value into the highest listed register. Its opcode is 5 (move), or 6 (return move) when that register is 15 in the user form.
- R8: In the user form, a mask without bit 15 sets `uop_user` on every access and on the final move that target a real register. A mask with bit 15 clears `uop_user`, and a load of register 15 that does not pass through scratch register 1 uses opcode 3.
- R9: A plain move (opcode 5) into register 15 sets `uop_branch`. It also sets `uop_ret` exactly when the base is register 13. All other micro-ops have both bits clear.
- R10: `uop_last` is set only on the final micro-op. After that micro-op is taken, `uop_valid` is low in the next cycle. After any other micro-op is taken, `uop_valid` stays high.
- R11: While `uop_valid` is high and `uop_ready` is low, every micro-op output holds its value.
- R12: `cmd_ready` is high only when no sequence is in progress, and a request offered during a sequence has no effect. A synchronous reset leaves the block idle with `uop_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Request offered |
| cmd_ready | output | 1 | Sequencer idle, request taken on this cycle |
| cmd_list | input | 16 | Register mask, bit i selects register i |
| cmd_base | input | 4 | Base register number |
| cmd_load | input | 1 | 1 load, 0 store |
| cmd_up | input | 1 | 1 ascending addresses, 0 descending |
| cmd_wb | input | 1 | Update the base after the transfer |
| cmd_user | input | 1 | User-bank or exception-return form |
| uop_valid | output | 1 | Micro-op presented |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_op | output | 3 | Opcode (0 add-imm, 1 sub-imm, 2 load, 3 return load, 4 store, 5 move, 6 return move) |
| uop_dst | output | 5 | Destination, or data register of a store |
| uop_src | output | 5 | Source or address register |
| uop_imm | output | 7 | Immediate or offset magnitude |
| uop_up | output | 1 | Direction bit of the request |
| uop_user | output | 1 | Register taken from the user bank |
| uop_branch | output | 1 | Indirect control transfer |
| uop_ret | output | 1 | Control transfer is a return |
| uop_last | output | 1 | Final micro-op of the sequence |
| uop_count | output | 5 | Micro-op count of the current sequence |

## Verification
The case hardest to reach from the ports is a move into register 15 in each of its three forms: as a plain branch, as a return through the stack pointer and as a return move in the user form. Each form depends on a different combination of mask, base and mode bits. The stimulus uses masks whose highest bit is 15, with base 13, with another base and with the user bit set. A consumer that stalls irregularly shows that outputs hold while not taken. A request kept asserted through a whole sequence, and a reset in mid-sequence, cover the idle-only acceptance rule.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
   typedef enum logic [2:0] {
      UOP_ADDI   = 3'd0,
      UOP_SUBI   = 3'd1,
      UOP_LDR    = 3'd2,
      UOP_LDRRET = 3'd3,
      UOP_STR    = 3'd4,
      UOP_MOV    = 3'd5,
      UOP_MOVRET = 3'd6
   } uop_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_COPY,
      ST_XFER,
      ST_BASE,
      ST_MOVE
   } seq_st_e;
endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
   parameter int W  = 16,
   localparam int NW = $clog2(W + 1)
) (
   input  logic [W-1:0]  bits_in,
   output logic [NW-1:0] ones
);
   always_comb begin
      ones = '0;
      for (int i = 0; i < W; i++)
         ones = ones + NW'(bits_in[i]);
   end
endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
   parameter int W  = 16,
   localparam int IW = $clog2(W)
) (
   input  logic [W-1:0]  mask,
   output logic [IW-1:0] idx,
   output logic          single
);
   always_comb begin
      idx = '0;
      for (int i = W - 1; i >= 0; i--)
         if (mask[i]) idx = IW'(i);
      single = (mask != '0) && ((mask & (mask - W'(1))) == '0);
   end
endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq #(
   parameter int LIST_W = 16,
   localparam int IW    = $clog2(LIST_W),
   localparam int RW    = IW + 1,
   localparam int IMM_W = IW + 3,
   localparam int CW    = $clog2(LIST_W + 4)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [LIST_W-1:0] cmd_list,
   input  logic [IW-1:0]     cmd_base,
   input  logic              cmd_load,
   input  logic              cmd_up,
   input  logic              cmd_wb,
   input  logic              cmd_user,
   output logic              uop_valid,
   input  logic              uop_ready,
   output logic [2:0]        uop_op,
   output logic [RW-1:0]     uop_dst,
   output logic [RW-1:0]     uop_src,
   output logic [IMM_W-1:0]  uop_imm,
   output logic              uop_up,
   output logic              uop_user,
   output logic              uop_branch,
   output logic              uop_ret,
   output logic              uop_last,
   output logic [CW-1:0]     uop_count
);
   import lsm_pkg::*;

   localparam int NW = $clog2(LIST_W + 1);
   localparam logic [RW-1:0] PC_R = RW'(LIST_W - 1);
   localparam logic [RW-1:0] SP_R = RW'(LIST_W - 3);
   localparam logic [RW-1:0] T0_R = RW'(LIST_W);
   localparam logic [RW-1:0] T1_R = RW'(LIST_W + 1);

   generate
      if (LIST_W < 4 || (LIST_W & (LIST_W - 1)) != 0) begin : g_bad_list
         $error("LIST_W must be a power of two, at least 4");
      end
      if (NW + 2 != IMM_W) begin : g_bad_imm
         $error("immediate width does not hold 4 * LIST_W");
      end
   endgenerate

   seq_st_e           st;
   logic [LIST_W-1:0] rem;
   logic [IW-1:0]     base_q;
   logic [IW-1:0]     lastreg_q;
   logic              ld_q, up_q, wb_q, fu_q, er_q;
   logic [NW-1:0]     n_q;
   logic [IMM_W-1:0]  mag_q;
   logic [CW-1:0]     cnt_q;

   logic [NW-1:0]     n_in;
   logic [IW-1:0]     lo_idx;
   logic              lo_single;
   logic              take, hit;
   logic [CW-1:0]     cnt_in;

   lsm_popcount #(.W(LIST_W)) u_pop (.bits_in(cmd_list), .ones(n_in));
   lsm_lowbit   #(.W(LIST_W)) u_low (.mask(rem), .idx(lo_idx), .single(lo_single));

   assign cmd_ready = (st == ST_IDLE);
   assign uop_valid = (st != ST_IDLE);
   assign take      = cmd_valid && cmd_ready;
   assign hit       = uop_valid && uop_ready;
   assign uop_count = cnt_q;
   assign uop_up    = up_q;

   always_comb begin
      if (n_in == '0)
         cnt_in = CW'(1);
      else if (cmd_wb)
         cnt_in = CW'(n_in) + CW'(cmd_load ? 3 : 2);
      else
         cnt_in = CW'(n_in) + CW'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st        <= ST_IDLE;
         rem       <= '0;
         base_q    <= '0;
         lastreg_q <= '0;
         ld_q      <= 1'b0;
         up_q      <= 1'b0;
         wb_q      <= 1'b0;
         fu_q      <= 1'b0;
         er_q      <= 1'b0;
         n_q       <= '0;
         mag_q     <= '0;
         cnt_q     <= '0;
      end else if (take) begin
         st     <= ST_COPY;
         rem    <= cmd_list;
         base_q <= cmd_base;
         ld_q   <= cmd_load;
         up_q   <= cmd_up;
         wb_q   <= cmd_wb;
         fu_q   <= cmd_user && !cmd_list[LIST_W-1];
         er_q   <= cmd_user && cmd_list[LIST_W-1];
         n_q    <= n_in;
         mag_q  <= cmd_up ? '0 : {n_in, 2'b00};
         cnt_q  <= cnt_in;
      end else if (hit) begin
         unique case (st)
            ST_COPY: st <= (n_q == '0) ? ST_IDLE : ST_XFER;
            ST_XFER: begin
               rem   <= rem & ~(LIST_W'(1) << lo_idx);
               mag_q <= up_q ? mag_q + IMM_W'(4) : mag_q - IMM_W'(4);
               if (lo_single) begin
                  lastreg_q <= lo_idx;
                  st        <= wb_q ? ST_BASE : ST_IDLE;
               end
            end
            ST_BASE: st <= ld_q ? ST_MOVE : ST_IDLE;
            ST_MOVE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      uop_op     = UOP_ADDI;
      uop_dst    = T0_R;
      uop_src    = RW'(base_q);
      uop_imm    = '0;
      uop_user   = 1'b0;
      uop_branch = 1'b0;
      uop_ret    = 1'b0;
      uop_last   = 1'b0;
      unique case (st)
         ST_COPY: uop_last = (n_q == '0);
         ST_XFER: begin
            uop_src  = T0_R;
            uop_imm  = mag_q;
            uop_dst  = RW'(lo_idx);
            uop_last = lo_single && !wb_q;
            if (!ld_q) begin
               uop_op   = UOP_STR;
               uop_user = fu_q;
            end else if (wb_q && lo_single) begin
               uop_op  = UOP_LDR;
               uop_dst = T1_R;
            end else if (RW'(lo_idx) == PC_R && er_q) begin
               uop_op = UOP_LDRRET;
            end else begin
               uop_op   = UOP_LDR;
               uop_user = fu_q;
            end
         end
         ST_BASE: begin
            uop_op   = up_q ? UOP_ADDI : UOP_SUBI;
            uop_dst  = RW'(base_q);
            uop_imm  = {n_q, 2'b00};
            uop_last = !ld_q;
         end
         ST_MOVE: begin
            uop_src  = T1_R;
            uop_dst  = RW'(lastreg_q);
            uop_last = 1'b1;
            if (RW'(lastreg_q) == PC_R && er_q) begin
               uop_op = UOP_MOVRET;
            end else begin
               uop_op     = UOP_MOV;
               uop_user   = fu_q;
               uop_branch = (RW'(lastreg_q) == PC_R);
               uop_ret    = (RW'(lastreg_q) == PC_R) && (RW'(base_q) == SP_R);
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/lsm_uop_seq_chk.sv
module lsm_uop_seq_chk #(
   parameter int LIST_W = 16,
   localparam int IW    = $clog2(LIST_W),
   localparam int RW    = IW + 1,
   localparam int IMM_W = IW + 3,
   localparam int CW    = $clog2(LIST_W + 4)
) (
   input logic             clk,
   input logic             rst,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic [IW-1:0]    cmd_base,
   input logic             uop_valid,
   input logic             uop_ready,
   input logic [2:0]       uop_op,
   input logic [RW-1:0]    uop_dst,
   input logic [RW-1:0]    uop_src,
   input logic [IMM_W-1:0] uop_imm,
   input logic             uop_user,
   input logic             uop_branch,
   input logic             uop_ret,
   input logic             uop_last,
   input logic [CW-1:0]    uop_count
);
   localparam logic [RW-1:0] T0_R = RW'(LIST_W);
   localparam logic [RW-1:0] T1_R = RW'(LIST_W + 1);

   // R11
   hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_op) && $stable(uop_dst)
         && $stable(uop_src) && $stable(uop_imm) && $stable(uop_user)
         && $stable(uop_branch) && $stable(uop_ret) && $stable(uop_last)
         && $stable(uop_count)));

   // R10
   last_ends_chk: assert property (@(posedge clk) disable iff (rst)
      (uop_valid && uop_ready && uop_last) |=> !uop_valid);

   // R10
   mid_continues_chk: assert property (@(posedge clk) disable iff (rst)
      (uop_valid && uop_ready && !uop_last) |=> uop_valid);

   // R3
   first_copy_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && cmd_ready) |=> (uop_valid && uop_op == 3'd0 && uop_dst == T0_R
         && uop_imm == '0 && uop_src == RW'($past(cmd_base))));

   // R4
   mem_src_chk: assert property (@(posedge clk) disable iff (rst)
      (uop_valid && (uop_op == 3'd2 || uop_op == 3'd3 || uop_op == 3'd4)) |-> uop_src == T0_R);

   // R7
   move_src_chk: assert property (@(posedge clk) disable iff (rst)
      (uop_valid && (uop_op == 3'd5 || uop_op == 3'd6)) |-> (uop_src == T1_R && uop_last));

   // R12
   reset_idle_chk: assert property (@(posedge clk)
      rst |=> (cmd_ready && !uop_valid));
endmodule

bind lsm_uop_seq lsm_uop_seq_chk #(.LIST_W(LIST_W)) u_chk (
   .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .cmd_base(cmd_base), .uop_valid(uop_valid), .uop_ready(uop_ready),
   .uop_op(uop_op), .uop_dst(uop_dst), .uop_src(uop_src), .uop_imm(uop_imm),
   .uop_user(uop_user), .uop_branch(uop_branch), .uop_ret(uop_ret),
   .uop_last(uop_last), .uop_count(uop_count));

// File: tb/lsm_uop_seq_test.sv
module lsm_uop_seq_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [15:0] cmd_list = '0;
   logic [3:0]  cmd_base = '0;
   logic        cmd_load = 1'b0, cmd_up = 1'b0, cmd_wb = 1'b0, cmd_user = 1'b0;
   logic        uop_valid;
   logic        uop_ready = 1'b0;
   logic [2:0]  uop_op;
   logic [4:0]  uop_dst, uop_src;
   logic [6:0]  uop_imm;
   logic        uop_up, uop_user, uop_branch, uop_ret, uop_last;
   logic [4:0]  uop_count;

   int checks = 0;
   int errors = 0;
   logic [15:0] lfsr = 16'hACE1;

   logic [24:0] exp_q[$];
   string       tag_q[$];
   int          exp_cnt;

   always #5 clk = ~clk;

   lsm_uop_seq uut (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_list(cmd_list), .cmd_base(cmd_base), .cmd_load(cmd_load), .cmd_up(cmd_up),
      .cmd_wb(cmd_wb), .cmd_user(cmd_user), .uop_valid(uop_valid), .uop_ready(uop_ready),
      .uop_op(uop_op), .uop_dst(uop_dst), .uop_src(uop_src), .uop_imm(uop_imm),
      .uop_up(uop_up), .uop_user(uop_user), .uop_branch(uop_branch), .uop_ret(uop_ret),
      .uop_last(uop_last), .uop_count(uop_count));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [24:0] pk(int op, int dst, int src, int imm, bit up,
                                      bit usr, bit br, bit ret, bit last);
      return {3'(op), 5'(dst), 5'(src), 7'(imm), up, usr, br, ret, last};
   endfunction

   task automatic push(logic [24:0] v, string t);
      exp_q.push_back(v);
      tag_q.push_back(t);
   endtask

   task automatic build(logic [15:0] lst, int base, bit ld, bit up, bit wb, bit usr);
      int n = 0, k = 0, hi = 0;
      bit fu = usr && !lst[15];
      bit er = usr && lst[15];
      for (int r = 0; r < 16; r++) if (lst[r]) begin n++; hi = r; end
      exp_cnt = (n == 0) ? 1 : n + 1 + (wb ? (ld ? 2 : 1) : 0);
      push(pk(0, 16, base, 0, up, 0, 0, 0, n == 0), n == 0 ? "R2" : "R3");
      if (n == 0) return;
      for (int r = 0; r < 16; r++) if (lst[r]) begin
         int mag = up ? 4 * k : 4 * (n - k);
         bit fin = (k == n - 1);
         if (!ld)
            push(pk(4, r, 16, mag, up, fu, 0, 0, fin && !wb), "R4");
         else if (wb && fin)
            push(pk(2, 17, 16, mag, up, 0, 0, 0, 0), "R5");
         else if (r == 15 && er)
            push(pk(3, 15, 16, mag, up, 0, 0, 0, fin), "R8");
         else
            push(pk(2, r, 16, mag, up, fu, 0, 0, fin), fu ? "R8" : "R4");
         k++;
      end
      if (wb) begin
         push(pk(up ? 0 : 1, base, base, 4 * n, up, 0, 0, 0, !ld), "R6");
         if (ld) begin
            if (hi == 15 && er)
               push(pk(6, 15, 17, 0, up, 0, 0, 0, 1), "R7");
            else
               push(pk(5, hi, 17, 0, up, fu, hi == 15, hi == 15 && base == 13, 1),
                    hi == 15 ? "R9" : "R7");
         end
      end
   endtask

   task automatic run(logic [15:0] lst, int base, bit ld, bit up, bit wb, bit usr,
                      bit stall, bit junk);
      build(lst, base, ld, up, wb, usr);
      @(negedge clk);
      chk(cmd_ready == 1'b1, "R12 idle before request", cmd_ready, 1);
      cmd_list = lst; cmd_base = 4'(base); cmd_load = ld; cmd_up = up;
      cmd_wb = wb; cmd_user = usr; cmd_valid = 1'b1;
      @(negedge clk);
      if (junk) begin
         cmd_list = 16'h00FF; cmd_base = 4'd7; cmd_load = ~ld; cmd_wb = 1'b1;
      end else cmd_valid = 1'b0;
      while (exp_q.size() > 0) begin
         bit r;
         chk(uop_valid == 1'b1, "R10 valid mid-sequence", uop_valid, 1);
         chk(cmd_ready == 1'b0, "R12 busy", cmd_ready, 0);
         chk(uop_count == 5'(exp_cnt), "R1 count", uop_count, exp_cnt);
         chk({uop_op, uop_dst, uop_src, uop_imm, uop_up, uop_user, uop_branch, uop_ret,
              uop_last} == exp_q[0], tag_q[0],
             {uop_op, uop_dst, uop_src, uop_imm, uop_up, uop_user, uop_branch, uop_ret,
              uop_last}, exp_q[0]);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         r = stall ? lfsr[0] : 1'b1;
         uop_ready = r;
         @(negedge clk);
         if (r) begin
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
         end
      end
      cmd_valid = 1'b0;
      uop_ready = 1'b0;
      chk(uop_valid == 1'b0, "R10 no micro-op after last", uop_valid, 0);
      chk(cmd_ready == 1'b1, "R12 idle after last", cmd_ready, 1);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(uop_valid == 1'b0 && cmd_ready == 1'b1, "R12 reset state", uop_valid, 0);
      rst = 1'b0;
      run(16'h0000, 3, 1, 1, 1, 0, 0, 0);   // R2 empty mask
      run(16'h00F1, 2, 0, 1, 0, 0, 0, 0);   // R4 store ascending
      run(16'h1234, 13, 0, 0, 1, 0, 1, 0);  // R6 store descending with update
      run(16'h00A6, 4, 1, 1, 1, 0, 1, 0);   // R5 R7 load with update
      run(16'h8003, 13, 1, 0, 1, 0, 1, 0);  // R9 return through stack pointer
      run(16'h8010, 5, 1, 1, 1, 0, 0, 0);   // R9 branch without return
      run(16'h6060, 1, 1, 1, 1, 1, 1, 0);   // R8 user bank load
      run(16'h0C03, 0, 0, 0, 0, 1, 0, 0);   // R8 user bank store
      run(16'h8101, 6, 1, 1, 0, 1, 0, 0);   // R8 return load
      run(16'hC000, 9, 1, 0, 1, 1, 1, 0);   // R7 return move
      run(16'h0008, 8, 1, 1, 1, 0, 0, 0);   // R1 single register
      run(16'h0212, 3, 1, 1, 0, 0, 1, 1);   // R12 request during sequence ignored
      run(16'hFFFF, 2, 1, 1, 1, 0, 1, 0);   // R1 R4 full mask
      run(16'hFFFF, 11, 0, 0, 1, 0, 0, 0);  // R6 full mask descending store
      // R12 reset in mid-sequence
      @(negedge clk);
      cmd_list = 16'h0F0F; cmd_base = 4'd1; cmd_load = 1'b1; cmd_up = 1'b1;
      cmd_wb = 1'b1; cmd_user = 1'b0; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0; uop_ready = 1'b1;
      repeat (3) @(negedge clk);
      chk(uop_valid == 1'b1, "R12 sequence running before reset", uop_valid, 1);
      rst = 1'b1; uop_ready = 1'b0;
      @(negedge clk);
      chk(uop_valid == 1'b0 && cmd_ready == 1'b1, "R12 reset mid-sequence", uop_valid, 0);
      rst = 1'b0;
      exp_q.delete(); tag_q.delete();
      run(16'h0005, 10, 1, 0, 1, 0, 0, 0);  // R3 clean start after reset
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule